// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase Numerically Controlled Oscillator

This block is the phase-generation core of a direct digital synthesizer. It is clocked by the master clock. On every active cycle it adds one of two 32-bit tuning words to a 32-bit phase accumulator, which wraps modulo 2^32. It then adds one of four 12-bit phase offsets to the top 12 accumulator bits to form a 12-bit output phase. The surrounding register file supplies the tuning words, the offsets and the control flags. A sine lookup and a converter downstream turn the phase into a waveform.

The frequency and phase choices come from one of two places. Either they come from select pins, for fast modulation, or they come from select bits held in the register file. A source flag picks between the two. A synchronous mode passes the selects and the tuning and offset words through two extra register stages, which adds exactly two master-clock cycles of latency. A clear flag parks the accumulator at zero phase. A sleep flag freezes every register in the core.

Top module: `nco_core`

## Requirements
- R1: While `rst` is high, at the next rising clock edge the accumulator, the output phase and both synchronizer stages become 0, so `phase_out` reads 0.
- R2: On each active edge (not sleeping, not clearing), the accumulator becomes the accumulator plus the chosen tuning word, modulo 2^32. Frequency select 0 chooses `ftw_flat[31:0]` and select 1 chooses `ftw_flat[63:32]`.
- R3: On each active edge, `phase_out` becomes the accumulator's top 12 bits (as they stood before that edge) plus the chosen offset, modulo 4096. Phase select value k = {psel[1],psel[0]} chooses `poff_flat[12k+11:12k]`.
- R4: When `sel_src` is 1, the selects come from `reg_fsel`/`reg_psel`. When `sel_src` is 0, they come from `pin_fsel`/`pin_psel`.
- R5: With `sync_en` = 0, a change of selects or words at the inputs reaches the accumulator at the next edge. A step of the tuning word from 0 to 2^28 first shows on `phase_out` two edges after it is applied.
- R6: With `sync_en` = 1, the same step first shows four edges after it is applied, which is exactly two edges later than in R5.
- R7: With `acc_clear` = 1 and `sleep_en` = 0, the accumulator is forced to 0 at every edge, so `phase_out` settles to the chosen offset alone.
- R8: With `sleep_en` = 1, every register holds its value: `phase_out` stays stable, and changes to the words, the selects and `acc_clear` have no effect until the core wakes.
- R9: With tuning word 2^28, offset 0 and the accumulator started at 0, `phase_out` advances by exactly 256 per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Freeze all core state |
| acc_clear | input | 1 | Park accumulator at zero phase |
| sync_en | input | 1 | Route selects and words through the two-stage synchronizer |
| sel_src | input | 1 | 1: register select bits, 0: select pins |
| pin_fsel | input | 1 | Frequency select pin |
| pin_psel | input | 2 | Phase select pins |
| reg_fsel | input | 1 | Frequency select register bit |
| reg_psel | input | 2 | Phase select register bits |
| ftw_flat | input | 64 | Two tuning words, word k at [32k+31:32k] |
| poff_flat | input | 48 | Four phase offsets, offset k at [12k+11:12k] |
| phase_out | output | 12 | Output phase |

## Verification
The bench measures the edge at which a tuning-word step first moves the phase, in both synchronizer settings. A design that lost or doubled a synchronizer stage would shift that edge away from two or four. It drives the pins and the register bits to opposite selects, so a source flag read backwards gives the wrong rate. It also parks the core asleep while it changes the words and pulses the clear. A core that did not freeze completely would move its phase, or wake up with a cleared accumulator. Random runs switch mode in mid-stream and cross the 2^32 wrap, so any slip in the offset index or in modular wrapping shows as a phase mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W    = 32;
    localparam int PH_W     = 12;
    localparam int NUM_FREQ = 2;
    localparam int NUM_PH   = 4;
    localparam int FSEL_W   = $clog2(NUM_FREQ);
    localparam int PSEL_W   = $clog2(NUM_PH);
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        logic [PSEL_W-1:0] psel;
    } nco_sel_t;

    typedef struct packed {
        logic [ACC_W-1:0] ftw;
        logic [PH_W-1:0]  off;
    } nco_word_t;

    function automatic nco_sel_t pick_sel(input logic use_reg,
                                          input nco_sel_t from_pin,
                                          input nco_sel_t from_reg);
        return use_reg ? from_reg : from_pin;
    endfunction
endpackage

// File: rtl/nco_sel_mux.sv
module nco_sel_mux
    import nco_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int PW = PH_W,
    parameter int NF = NUM_FREQ,
    parameter int NP = NUM_PH
) (
    input  logic            sel_src,
    input  nco_sel_t        sel_pin,
    input  nco_sel_t        sel_reg,
    input  logic [NF*AW-1:0] ftw_flat,
    input  logic [NP*PW-1:0] poff_flat,
    output nco_word_t       word
);
    nco_sel_t sel;

    always_comb begin
        sel      = pick_sel(sel_src, sel_pin, sel_reg);
        word.ftw = ftw_flat[sel.fsel*AW +: AW];
        word.off = poff_flat[sel.psel*PW +: PW];
    end
endmodule

// File: rtl/nco_sync_pipe.sv
module nco_sync_pipe #(
    parameter int W     = 44,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         bypass,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)        stg[i] <= '0;
                else if (!hold) stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)        stg[i] <= '0;
                else if (!hold) stg[i] <= stg[i-1];
            end
        end
    end

    assign q = bypass ? d : stg[DEPTH-1];
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int AW = 32,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          clear,
    input  logic [AW-1:0] ftw,
    input  logic [PW-1:0] off,
    output logic [AW-1:0] acc_q,
    output logic [PW-1:0] phase_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            phase_q <= '0;
        end else if (!hold) begin
            phase_q <= acc_q[AW-1 -: PW] + off;
            acc_q   <= clear ? '0 : acc_q + ftw;
        end
    end
endmodule

// File: rtl/nco_core.sv
module nco_core
    import nco_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep_en,
    input  logic                    acc_clear,
    input  logic                    sync_en,
    input  logic                    sel_src,
    input  logic [FSEL_W-1:0]       pin_fsel,
    input  logic [PSEL_W-1:0]       pin_psel,
    input  logic [FSEL_W-1:0]       reg_fsel,
    input  logic [PSEL_W-1:0]       reg_psel,
    input  logic [NUM_FREQ*ACC_W-1:0] ftw_flat,
    input  logic [NUM_PH*PH_W-1:0]  poff_flat,
    output logic [PH_W-1:0]         phase_out
);
    localparam int WORD_W = ACC_W + PH_W;

    nco_sel_t  sel_pin, sel_reg;
    nco_word_t word_now, word_eff;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] ftw_eff;
    logic [PH_W-1:0]  off_eff;

    assign sel_pin = '{fsel: pin_fsel, psel: pin_psel};
    assign sel_reg = '{fsel: reg_fsel, psel: reg_psel};

    nco_sel_mux u_mux (
        .sel_src   (sel_src),
        .sel_pin   (sel_pin),
        .sel_reg   (sel_reg),
        .ftw_flat  (ftw_flat),
        .poff_flat (poff_flat),
        .word      (word_now)
    );

    nco_sync_pipe #(.W(WORD_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .hold   (sleep_en),
        .bypass (!sync_en),
        .d      (word_now),
        .q      (word_eff)
    );

    assign ftw_eff = word_eff.ftw;
    assign off_eff = word_eff.off;

    nco_accum #(.AW(ACC_W), .PW(PH_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .hold    (sleep_en),
        .clear   (acc_clear),
        .ftw     (ftw_eff),
        .off     (off_eff),
        .acc_q   (acc_q),
        .phase_q (phase_out)
    );
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk
    import nco_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    sleep_en,
    input logic                    acc_clear,
    input logic                    sync_en,
    input logic                    sel_src,
    input logic [FSEL_W-1:0]       pin_fsel,
    input logic [FSEL_W-1:0]       reg_fsel,
    input logic [NUM_FREQ*ACC_W-1:0] ftw_flat,
    input logic [PH_W-1:0]         phase_out,
    input logic [ACC_W-1:0]        acc_q,
    input logic [ACC_W-1:0]        ftw_eff,
    input logic [PH_W-1:0]         off_eff
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (phase_out == '0 && acc_q == '0));

    p_accumulate_r2: assert property (@(posedge clk) disable iff (rst)
        (!sleep_en && !acc_clear) |=> acc_q == $past(acc_q) + $past(ftw_eff));

    p_phase_sum_r3: assert property (@(posedge clk) disable iff (rst)
        !sleep_en |=> phase_out == $past(acc_q[ACC_W-1 -: PH_W]) + $past(off_eff));

    p_source_pick_r4: assert property (@(posedge clk) disable iff (rst)
        !sync_en |-> ftw_eff == ftw_flat[(sel_src ? reg_fsel : pin_fsel)*ACC_W +: ACC_W]);

    p_clear_park_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_clear && !sleep_en) |=> acc_q == '0);

    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (rst)
        sleep_en |=> ($stable(phase_out) && $stable(acc_q)));
endmodule

bind nco_core nco_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_en  (sleep_en),
    .acc_clear (acc_clear),
    .sync_en   (sync_en),
    .sel_src   (sel_src),
    .pin_fsel  (pin_fsel),
    .reg_fsel  (reg_fsel),
    .ftw_flat  (ftw_flat),
    .phase_out (phase_out),
    .acc_q     (acc_q),
    .ftw_eff   (ftw_eff),
    .off_eff   (off_eff)
);

// File: tb/sim_nco_core.sv
`timescale 1ns/1ps
module sim_nco_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_en = 0, acc_clear = 0, sync_en = 0, sel_src = 0;
    logic        pin_fsel = 0, reg_fsel = 0;
    logic [1:0]  pin_psel = 0, reg_psel = 0;
    logic [63:0] ftw_flat = '0;
    logic [47:0] poff_flat = '0;
    logic [11:0] phase_out;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nco_core u0 (.*);

    // independent reference state
    logic [31:0] m_acc, p0f, p1f;
    logic [11:0] m_ph, p0o, p1o;

    function automatic logic [31:0] exp_ftw(input logic src, input logic pf, input logic rf,
                                            input logic [63:0] w);
        logic f;
        f = src ? rf : pf;
        return f ? w[63:32] : w[31:0];
    endfunction

    function automatic logic [11:0] exp_off(input logic src, input logic [1:0] pp,
                                            input logic [1:0] rp, input logic [47:0] w);
        logic [1:0] k;
        k = src ? rp : pp;
        case (k)
            2'd0: return w[11:0];
            2'd1: return w[23:12];
            2'd2: return w[35:24];
            default: return w[47:36];
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] bf, ef;
        logic [11:0] bo, eo;
        cyc = cyc + 1;
        bf = exp_ftw(sel_src, pin_fsel, reg_fsel, ftw_flat);
        bo = exp_off(sel_src, pin_psel, reg_psel, poff_flat);
        if (rst) begin
            m_acc = 0; m_ph = 0; p0f = 0; p1f = 0; p0o = 0; p1o = 0;
        end else if (!sleep_en) begin
            ef = sync_en ? p1f : bf;
            eo = sync_en ? p1o : bo;
            m_ph  = m_acc[31:20] + eo;
            m_acc = acc_clear ? 32'd0 : m_acc + ef;
            p1f = p0f; p1o = p0o; p0f = bf; p0o = bo;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // counts edges until phase_out leaves zero after a tuning step
    task automatic measure_latency(input bit sy, output int edges);
        sync_en = sy; sel_src = 0; pin_fsel = 0; pin_psel = 0;
        poff_flat = '0; ftw_flat = '0; acc_clear = 1;
        repeat (4) step();
        acc_clear = 0; step();
        ftw_flat[31:0] = 32'h1000_0000;
        edges = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            edges++;
            if (phase_out != 0) break;
        end
    endtask

    initial begin : wd
        while (!done && cyc < 100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lat0, lat1;
        logic [11:0] prev, held;
        void'($urandom(32'd1234));
        repeat (3) step();
        // R1 reset state
        chk(phase_out == 0, "R1 reset phase", phase_out, 0);
        rst = 0;

        // R5 / R6 latency, R9 step size
        measure_latency(0, lat0);
        chk(lat0 == 2, "R5 latency no-sync", lat0, 2);
        prev = phase_out;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(phase_out == prev + 12'd256, "R9 step 256", phase_out, prev + 12'd256);
            prev = phase_out;
        end
        measure_latency(1, lat1);
        chk(lat1 == 4, "R6 latency sync", lat1, 4);
        chk(lat1 - lat0 == 2, "R6 extra latency", lat1 - lat0, 2);

        // R4 source: pins and register bits point at opposite words
        sync_en = 0; ftw_flat = {32'h1000_0000, 32'd0};
        sel_src = 1; reg_fsel = 1; pin_fsel = 0;
        repeat (2) step();
        prev = phase_out; step();
        chk(phase_out == prev + 12'd256, "R4 register source", phase_out, prev + 12'd256);
        sel_src = 0;
        repeat (2) step();
        prev = phase_out; step();
        chk(phase_out == prev, "R4 pin source", phase_out, prev);

        // R3 offset index: offset k = 100*(k+1)
        poff_flat = {12'd400, 12'd300, 12'd200, 12'd100};
        ftw_flat = '0; acc_clear = 1;
        for (int k = 0; k < 4; k++) begin
            pin_psel = k[1:0];
            repeat (2) step();
            // R7 parked accumulator shows offset alone
            chk(phase_out == 12'(100 * (k + 1)), "R3 R7 offset index", phase_out, 100 * (k + 1));
        end
        acc_clear = 0;

        // R8 sleep: freeze while words, selects and clear change
        ftw_flat = {32'h0300_0000, 32'h1234_5678};
        repeat (3) step();
        sleep_en = 1; step();
        held = phase_out;
        acc_clear = 1; ftw_flat = 64'hFFFF_FFFF_FFFF_FFFF; pin_psel = 2'd3;
        for (int i = 0; i < 5; i++) begin
            step();
            chk(phase_out == held, "R8 sleep hold", phase_out, held);
        end
        acc_clear = 0; ftw_flat = {32'h0300_0000, 32'h1234_5678}; pin_psel = 0;
        sleep_en = 0;
        step();
        chk(phase_out == m_ph, "R8 wake no clear", phase_out, m_ph);

        // random mix checked against reference state (R2 R3 R6 R7 R8)
        for (int i = 0; i < 3000; i++) begin
            ftw_flat  = {$urandom(), $urandom()};
            poff_flat = {16'($urandom()), $urandom()};
            pin_fsel = 1'($urandom()); reg_fsel = 1'($urandom());
            pin_psel = 2'($urandom()); reg_psel = 2'($urandom());
            sel_src  = 1'($urandom());
            if ($urandom_range(0, 99) < 5) sync_en = ~sync_en;
            sleep_en  = ($urandom_range(0, 99) < 8);
            acc_clear = ($urandom_range(0, 99) < 4);
            step();
            chk(phase_out == m_ph, sync_en ? "R2 R6 random" : "R2 R3 random", phase_out, m_ph);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule